// File: doc/BRIEF.md
# Write-Enable Latch and Block-Protect Write Gate

This block sits in the write path of a serially accessed memory that has a small space of control and status registers next to a 32 KiB byte array. It holds a volatile write-enable latch and a 3-bit block-protect code. For every write that the bus front end presents, it decides in the same cycle whether the write is taken. It returns an accept or a no-acknowledge indication and says whether a nonvolatile programming cycle has to start.

The latch changes only on a status-register write that carries one of two exact data patterns. Arm is 0x02, with enable bit 1 set and every other bit clear. Disarm is 0x00. These writes never start a programming cycle, so the device is ready again as soon as the bus transaction ends. When the latch is clear, all array and control-register writes are refused. When the latch is set, an array write is still refused if its address falls inside the window that the protect code selects. The protect code can select the upper quarter, the upper half or all of the array. It can also select the first 1, 2, 4 or 8 pages of 128 bytes.

Top module: `wr_guard`

## Requirements
- R1: During a cycle with rst_n low, the latch is cleared and the protect code is set to 000. The status readback `sr_rdata` reads 0x00 and `bp_code` reads 000 from the next cycle.
- R2: While the latch is clear, a strobed array write or non-status control write gives `wr_accept`=0 and `wr_nack`=1, and `nv_start`=0. A refused write to the protect register at control address 0x0010 leaves `bp_code` unchanged.
- R3: A status-register write is one with `wr_ctrl`=1 and address 0x003F. When its data is 0x02, it is accepted and the latch reads 1 from the next cycle (`sr_rdata`=0x02).
- R4: A status-register write with data 0x00 is accepted, and the latch reads 0 from the next cycle (`sr_rdata`=0x00).
- R5: A status-register write with any other data is refused (`wr_nack`=1), and the latch keeps its value.
- R6: With the latch set, protect code 000 refuses no array address. Code 001 refuses 0x6000–0x7FFF. Code 010 refuses 0x4000–0x7FFF. Code 011 refuses every address. Addresses outside the window are accepted.
- R7: With the latch set, protect code 100 refuses 0x0000–0x007F. Code 101 refuses 0x0000–0x00FF. Code 110 refuses 0x0000–0x01FF. Code 111 refuses 0x0000–0x03FF. Higher addresses are accepted.
- R8: The accept decision is combinational in the strobe cycle. Without `wr_strobe`, the outputs `wr_accept`, `wr_nack` and `nv_start` are all 0.
- R9: An accepted array or non-status control write raises `nv_start` in the strobe cycle. A status-register write never raises `nv_start`.
- R10: The status readback carries the latch in bit 1, and every other bit, including bits 3 and 4, reads 0.
- R11: An accepted write to control address 0x0010 loads `bp_code` from data bits [7:5] on the next cycle. The protect code never refuses writes to control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | One-cycle write request from the bus front end |
| wr_ctrl | input | 1 | 1 = control/status register target, 0 = array target |
| wr_addr | input | 15 | Target byte or register address |
| wr_data | input | 8 | Write data byte |
| wr_accept | output | 1 | Write is taken (acknowledge) |
| wr_nack | output | 1 | Write is dropped (no acknowledge) |
| nv_start | output | 1 | Start a nonvolatile programming cycle |
| sr_rdata | output | 8 | Status register readback |
| bp_code | output | 3 | Current block-protect code |

## Verification
The hardest states to reach are the protect-window edges for the four page-window codes. Reaching them needs three steps in order: arm the latch, program the protect register while the latch stays set, and then hit the addresses on each side of the window limit. Each protect scenario task goes through that sequence for one code and probes both the last refused and the first accepted address. A second task checks that a refused protect-register write leaves the code unchanged, by reading `bp_code` after the write. Malformed status patterns are sent both while the latch is set and while it is clear, so that both directions of "no change" show on `sr_rdata`.

// File: rtl/wr_guard_pkg.sv
// Package wr_guard_pkg
// Shared sizes and target classification for the write gate.
// Assumes a byte-wide data path and a 15-bit address space.
package wr_guard_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int BP_W   = 3;

    // Kind of target a strobed write addresses
    typedef enum logic [1:0] {
        TGT_ARRAY  = 2'd0,
        TGT_STATUS = 2'd1,
        TGT_CTRL   = 2'd2
    } tgt_kind_e;
endpackage

// File: rtl/wel_latch.sv
// Module wel_latch
// Holds the volatile write-enable latch. Only two exact status patterns
// move it: arm (enable bit set, rest clear) and disarm (all clear).
// Assumes sr_wr is a one-cycle qualified status-register write.
module wel_latch #(
    parameter int DATA_W  = 8,
    parameter int WEL_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_data,
    output logic              pattern_ok,
    output logic              wel
);
    localparam logic [DATA_W-1:0] ARM_PAT    = DATA_W'(1) << WEL_BIT;
    localparam logic [DATA_W-1:0] DISARM_PAT = '0;

    logic is_arm;
    logic is_disarm;

    // Classify the incoming status data against the two legal patterns
    always_comb begin
        is_arm     = (sr_data == ARM_PAT);
        is_disarm  = (sr_data == DISARM_PAT);
        pattern_ok = is_arm || is_disarm;
    end

    // Latch update: reset clears, legal patterns set or clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (sr_wr && is_arm) begin
            wel <= 1'b1;
        end else if (sr_wr && is_disarm) begin
            wel <= 1'b0;
        end
    end

    // R1: reset leaves the latch clear
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !wel);

    // R3: arm pattern sets the latch
    p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_data == ARM_PAT) |=> wel);

    // R4: disarm pattern clears the latch
    p_disarm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_data == DISARM_PAT) |=> !wel);

    // R5: any other pattern leaves the latch alone
    p_odd_pattern_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_data != ARM_PAT && sr_data != DISARM_PAT) |=> $stable(wel));
endmodule

// File: rtl/bp_window.sv
// Module bp_window
// Decodes the block-protect code into a hit flag for one array address.
// Code msb 0: upper fraction of the array (none, quarter, half, all).
// Code msb 1: first 1/2/4/8 pages of PAGE_BYTES from address zero.
// Assumes ADDR_W >= 3 and PAGE_BYTES << 3 fits in the address space.
module bp_window #(
    parameter int ADDR_W     = 15,
    parameter int BP_W       = 3,
    parameter int PAGE_BYTES = 128
) (
    input  logic [BP_W-1:0]   code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int N_LIM = 4;
    localparam logic [ADDR_W:0] PAGE_W = (ADDR_W+1)'(PAGE_BYTES);

    logic [ADDR_W:0] page_lim [N_LIM];
    logic            upper_hit;
    logic            page_hit;

    // One window limit per page-count choice
    for (genvar g = 0; g < N_LIM; g++) begin : g_lim
        assign page_lim[g] = PAGE_W << g;
    end

    // Upper-fraction decode on the top address bits
    always_comb begin
        unique case (code[1:0])
            2'b00:   upper_hit = 1'b0;
            2'b01:   upper_hit = addr[ADDR_W-1] && addr[ADDR_W-2];
            2'b10:   upper_hit = addr[ADDR_W-1];
            default: upper_hit = 1'b1;
        endcase
    end

    // First-pages decode against the selected limit
    always_comb begin
        page_hit = ({1'b0, addr} < page_lim[code[1:0]]);
    end

    // Pick the family by the code msb
    always_comb begin
        hit = code[BP_W-1] ? page_hit : upper_hit;
    end

    // R6: code 000 never protects
    always_comb begin
        if (code == '0) begin
            a_none_r6: assert (!hit);
        end
    end

    // R7: the page family never reaches the upper half of the array
    always_comb begin
        if (code[BP_W-1] && addr[ADDR_W-1]) begin
            a_page_low_r7: assert (!hit);
        end
    end
endmodule

// File: rtl/wr_guard.sv
// Module wr_guard
// Write gate in front of the array and the control registers. It keeps
// the write-enable latch and the protect code, decides accept or
// no-acknowledge in the strobe cycle and flags writes that need a
// nonvolatile programming cycle. Status writes never need one.
// Assumes wr_strobe is a one-cycle pulse per data byte.
module wr_guard
    import wr_guard_pkg::*;
#(
    parameter int                SR_ADDR    = 'h003F,
    parameter int                BP_ADDR    = 'h0010,
    parameter int                BP_LSB     = 5,
    parameter int                WEL_BIT    = 1,
    parameter int                PAGE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              wr_ctrl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_accept,
    output logic              wr_nack,
    output logic              nv_start,
    output logic [DATA_W-1:0] sr_rdata,
    output logic [BP_W-1:0]   bp_code
);
    localparam logic [ADDR_W-1:0] SR_A = ADDR_W'(SR_ADDR);
    localparam logic [ADDR_W-1:0] BP_A = ADDR_W'(BP_ADDR);

    tgt_kind_e       kind;
    logic            sr_wr;
    logic            pattern_ok;
    logic            wel;
    logic            prot_hit;
    logic [BP_W-1:0] bp_q;

    // Classify the target of the current address
    always_comb begin
        if (!wr_ctrl)              kind = TGT_ARRAY;
        else if (wr_addr == SR_A)  kind = TGT_STATUS;
        else                       kind = TGT_CTRL;
        sr_wr = wr_strobe && (kind == TGT_STATUS);
    end

    wel_latch #(
        .DATA_W  (DATA_W),
        .WEL_BIT (WEL_BIT)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr      (sr_wr),
        .sr_data    (wr_data),
        .pattern_ok (pattern_ok),
        .wel        (wel)
    );

    bp_window #(
        .ADDR_W     (ADDR_W),
        .BP_W       (BP_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_window (
        .code (bp_q),
        .addr (wr_addr),
        .hit  (prot_hit)
    );

    // Same-cycle accept decision per target kind
    always_comb begin
        wr_accept = 1'b0;
        nv_start  = 1'b0;
        if (wr_strobe) begin
            unique case (kind)
                TGT_STATUS: wr_accept = pattern_ok;
                TGT_CTRL:   wr_accept = wel;
                default:    wr_accept = wel && !prot_hit;
            endcase
            nv_start = wr_accept && (kind != TGT_STATUS);
        end
        wr_nack = wr_strobe && !wr_accept;
    end

    // Protect code register, loaded by an accepted write to its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q <= '0;
        end else if (wr_accept && kind == TGT_CTRL && wr_addr == BP_A) begin
            bp_q <= wr_data[BP_LSB +: BP_W];
        end
    end

    // Status readback: latch in its bit, all else zero
    always_comb begin
        sr_rdata          = '0;
        sr_rdata[WEL_BIT] = wel;
    end

    assign bp_code = bp_q;

    // R2: clear latch refuses array and control writes
    p_locked_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !wel && kind != TGT_STATUS) |-> (wr_nack && !nv_start));

    // R6: a protected array address is never taken
    p_protected_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && kind == TGT_ARRAY && prot_hit) |-> !wr_accept);

    // R8: no strobe, no decision outputs
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |-> (!wr_accept && !wr_nack && !nv_start));

    // R9: status writes never start a programming cycle
    p_sr_no_nv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |-> !nv_start);

    // R11: protect code moves only after an accepted write
    p_bp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_ctrl) |=> $stable(bp_code));
endmodule

// File: tb/wr_guard_bench.sv
module wr_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_strobe;
    logic        wr_ctrl;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_accept;
    logic        wr_nack;
    logic        nv_start;
    logic [7:0]  sr_rdata;
    logic [2:0]  bp_code;

    int n_checks = 0;
    int n_fail   = 0;
    logic got_acc, got_nack, got_nv;

    localparam logic [14:0] SR_A = 15'h003F;
    localparam logic [14:0] BP_A = 15'h0010;

    always #5 clk = ~clk;

    wr_guard u_wr_guard (
        .clk (clk), .rst_n (rst_n), .wr_strobe (wr_strobe), .wr_ctrl (wr_ctrl),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_accept (wr_accept),
        .wr_nack (wr_nack), .nv_start (nv_start), .sr_rdata (sr_rdata),
        .bp_code (bp_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one write at negedge, capture the same-cycle decision, finish after posedge
    task automatic do_write(input logic ctrl, input logic [14:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_strobe = 1'b1; wr_ctrl = ctrl; wr_addr = addr; wr_data = data;
        #1;
        got_acc = wr_accept; got_nack = wr_nack; got_nv = nv_start;
        @(posedge clk);
        #1;
        wr_strobe = 1'b0;
    endtask

    task automatic set_code(input logic [2:0] c);
        do_write(1'b1, SR_A, 8'h02);
        do_write(1'b1, BP_A, {c, 5'b0});
        check("R11 code load", bp_code, c);
    endtask

    task automatic probe(input string req, input logic [14:0] addr, input logic exp_acc);
        do_write(1'b0, addr, 8'hA5);
        check(req, got_acc, exp_acc);
        check(req, got_nack, !exp_acc);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wr_strobe = 0; wr_ctrl = 0; wr_addr = 0; wr_data = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 sr_rdata", sr_rdata, 8'h00);
        check("R1 bp_code", bp_code, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_strobe = 0; wr_ctrl = 1; wr_addr = SR_A; wr_data = 8'h02;
        #1;
        check("R8 idle accept", wr_accept, 0);
        check("R8 idle nack", wr_nack, 0);
        check("R8 idle nv", nv_start, 0);
    endtask

    task automatic t_locked;
        do_write(1'b0, 15'h1234, 8'h11);
        check("R2 array nack", got_nack, 1);
        check("R2 array nv", got_nv, 0);
        do_write(1'b1, BP_A, 8'hE0);
        check("R2 ctrl nack", got_nack, 1);
        check("R2 bp unchanged", bp_code, 3'd0);
    endtask

    task automatic t_arm_disarm;
        do_write(1'b1, SR_A, 8'h02);
        check("R3 accept", got_acc, 1);
        check("R9 sr no nv", got_nv, 0);
        check("R3 latch set", sr_rdata, 8'h02);
        check("R10 unused bits", sr_rdata & 8'hFD, 8'h00);
        do_write(1'b1, SR_A, 8'h00);
        check("R4 accept", got_acc, 1);
        check("R9 sr no nv", got_nv, 0);
        check("R4 latch clear", sr_rdata, 8'h00);
    endtask

    task automatic t_odd_patterns;
        do_write(1'b1, SR_A, 8'h06);
        check("R5 nack clear", got_nack, 1);
        check("R5 still clear", sr_rdata, 8'h00);
        do_write(1'b1, SR_A, 8'h02);
        do_write(1'b1, SR_A, 8'h01);
        check("R5 nack set", got_nack, 1);
        check("R5 still set", sr_rdata, 8'h02);
        do_write(1'b1, SR_A, 8'h18);
        check("R5 still set 2", sr_rdata, 8'h02);
    endtask

    task automatic t_nv_ctrl;
        do_write(1'b1, SR_A, 8'h02);
        do_write(1'b1, 15'h0011, 8'h55);
        check("R9 ctrl accept", got_acc, 1);
        check("R9 ctrl nv", got_nv, 1);
        do_write(1'b0, 15'h0100, 8'h55);
        check("R9 array nv", got_nv, 1);
    endtask

    task automatic t_upper;
        set_code(3'b000);
        probe("R6 c0 low", 15'h0000, 1);
        probe("R6 c0 high", 15'h7FFF, 1);
        set_code(3'b001);
        probe("R6 c1 below", 15'h5FFF, 1);
        probe("R6 c1 edge", 15'h6000, 0);
        probe("R6 c1 top", 15'h7FFF, 0);
        set_code(3'b010);
        probe("R6 c2 below", 15'h3FFF, 1);
        probe("R6 c2 edge", 15'h4000, 0);
        set_code(3'b011);
        probe("R6 c3 zero", 15'h0000, 0);
        probe("R6 c3 top", 15'h7FFF, 0);
        do_write(1'b1, 15'h0011, 8'h00);
        check("R11 ctrl not protected", got_acc, 1);
    endtask

    task automatic t_pages;
        set_code(3'b100);
        probe("R7 c4 last", 15'h007F, 0);
        probe("R7 c4 next", 15'h0080, 1);
        set_code(3'b101);
        probe("R7 c5 last", 15'h00FF, 0);
        probe("R7 c5 next", 15'h0100, 1);
        set_code(3'b110);
        probe("R7 c6 last", 15'h01FF, 0);
        probe("R7 c6 next", 15'h0200, 1);
        set_code(3'b111);
        probe("R7 c7 zero", 15'h0000, 0);
        probe("R7 c7 last", 15'h03FF, 0);
        probe("R7 c7 next", 15'h0400, 1);
        probe("R7 c7 top", 15'h7FFF, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_locked();
        t_arm_disarm();
        t_odd_patterns();
        t_nv_ctrl();
        t_upper();
        t_pages();
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule